// File: doc/BRIEF.md
# Multi-Format PCM Serial Receiver

This block receives stereo PCM audio over a three-wire serial link: a bit clock, a frame clock that toggles once per half-frame, and a serial data line. It runs directly on the bit clock and samples the frame clock and data on every rising edge. Each half-frame carries one channel word, sent most significant bit first in two's complement. The block turns the left and right words into 24-bit samples and presents them as a pair with a one-cycle valid strobe once per frame.

A 2-bit format input chooses one of four framings at run time. Two formats are right-justified, carrying 16-bit or 24-bit words, and the receiver finds the word by counting back from the end of the half-frame. The third is a 24-bit left-justified format. The fourth is the one-bit-delayed I2S framing. A second serial data input can be used as the source when the control-mode and source-select inputs both ask for it.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first reported frame, `sample_valid` is 0 and both sample outputs are 0.
- R2: Data is sampled on the rising clock edge, most significant bit first, and is kept as 24-bit two's complement. Full-scale words 7FFFFF and 800000 pass through unchanged.
- R3: With `fmt` = 2'b10 (24-bit left-justified) the MSB is the first bit sampled after a frame-clock change, and 24 bits follow. Frame clock high carries the left word. Later slots in the half-frame are ignored.
- R4: With `fmt` = 2'b11 (I2S) the MSB is the second bit sampled after a frame-clock change, and frame clock low carries the left word. A half-frame of S slots, with 16 ≤ S < 24, yields S bits left-aligned, with the remaining low bits zero. At 32 bit clocks per frame this gives a 16-bit word.
- R5: With `fmt` = 2'b01 (24-bit right-justified) the word's LSB is the last slot of its half-frame and the word fills the last 24 slots. Earlier slots are ignored, and frame clock high carries the left word.
- R6: With `fmt` = 2'b00 (16-bit right-justified) the last 16 slots of the half-frame form the word. It is output as {word, 8'h00}.
- R7: `sample_valid` is a single-cycle pulse that follows the end of a right half-frame preceded by a complete left half-frame. The two sample outputs change only in the cycle in which `sample_valid` is 1.
- R8: A frame whose left or right half-frame is shorter than the minimum produces no pulse and leaves the outputs unchanged. The minimum is 24 slots for `fmt` 2'b01 and 2'b10, and 16 slots for 2'b00 and 2'b11.
- R9: Data comes from `sdata_sec` only when `ctl_3wire` and `sec_sel` are both 1. Otherwise it comes from `sdata_pri`.
- R10: A half-frame that is already in progress when reset is released is never reported, and neither is the frame it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lrclk | input | 1 | Frame clock marking the channel of each half-frame |
| sdata_pri | input | 1 | Primary serial data |
| sdata_sec | input | 1 | Secondary serial data |
| fmt | input | 2 | Framing: 00 RJ16, 01 RJ24, 10 LJ24, 11 I2S |
| ctl_3wire | input | 1 | Control-mode flag enabling the secondary source |
| sec_sel | input | 1 | Selects the secondary source when enabled |
| left_out | output | WORD_W | Latest left sample |
| right_out | output | WORD_W | Latest right sample |
| sample_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The assertions assume that `fmt` and the source selects change only while reset is asserted. This matters because the edge check compares the frame clock against its value one bit clock earlier, and a format change mid-stream would move the I2S delay tap. They also assume that every half-frame spans at least the minimum slot count whenever a pulse is expected. The stimulus follows both assumptions: it switches format and source only inside a reset phase, and it builds every frame slot by slot from a whole half-frame length, with short frames sent deliberately and expected to stay silent.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    // Framing codes; the numeric values are the external encoding of fmt.
    typedef enum logic [1:0] {
        FMT_RJ16 = 2'b00,
        FMT_RJ24 = 2'b01,
        FMT_LJ24 = 2'b10,
        FMT_I2S  = 2'b11
    } fmt_e;

endpackage

// File: rtl/pcm_rx_frame_sync.sv
module pcm_rx_frame_sync
    import pcm_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lrclk,
    input  fmt_e fmt,
    output logic half_start,
    output logic half_close,
    output logic closed_left
);

    typedef struct packed {
        logic       lr_dly;
        logic       lr_prev;
        logic [1:0] warm;
        logic       started;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  lr_eff;
    logic  armed;

    always_comb begin
        // I2S data trails the frame clock by one slot; delaying the clock
        // turns it into a left-justified stream with inverted polarity.
        lr_eff      = (fmt == FMT_I2S) ? sync_q.lr_dly : lrclk;
        armed       = (sync_q.warm == 2'd2);
        half_start  = armed && (lr_eff != sync_q.lr_prev);
        half_close  = half_start && sync_q.started;
        closed_left = (fmt == FMT_I2S) ? ~sync_q.lr_prev : sync_q.lr_prev;

        sync_d         = sync_q;
        sync_d.lr_dly  = lrclk;
        sync_d.lr_prev = lr_eff;
        if (!armed) begin
            sync_d.warm = sync_q.warm + 2'd1;
        end
        if (half_start) begin
            sync_d.started = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // R3: in the justified framings a new half starts exactly on a frame-clock change
    assert_edge_justified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && fmt != FMT_I2S) |-> (half_start == (lrclk != $past(lrclk))));

    // R10: nothing is closed before the first half boundary seen after reset
    assert_no_early_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_q.started) |-> !half_close);

endmodule

// File: rtl/pcm_rx_word_asm.sv
module pcm_rx_word_asm
    import pcm_rx_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 16,
    parameter int CNT_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              fmt,
    input  logic              sbit,
    input  logic              half_start,
    output logic [WORD_W-1:0] word,
    output logic              word_ok
);

    localparam int PAD_W = WORD_W - SHORT_W;
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] NEED_FUL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] NEED_SHT = CNT_W'(SHORT_W);

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
    } asm_t;

    asm_t asm_d, asm_q;
    logic lsb_mode;

    always_comb begin
        lsb_mode = (fmt == FMT_RJ16) || (fmt == FMT_RJ24);

        asm_d = asm_q;
        if (half_start) begin
            asm_d.cnt = CNT_W'(1);
            asm_d.acc = '0;
            if (lsb_mode) begin
                asm_d.acc[0] = sbit;
            end else begin
                asm_d.acc[WORD_W-1] = sbit;
            end
        end else begin
            if (asm_q.cnt != CNT_MAX) begin
                asm_d.cnt = asm_q.cnt + CNT_W'(1);
            end
            if (lsb_mode) begin
                // Right-justified: keep the newest bits; the final ones win.
                asm_d.acc = {asm_q.acc[WORD_W-2:0], sbit};
            end else begin
                // Left-justified: place slot i at bit WORD_W-1-i, drop the rest.
                for (int i = 0; i < WORD_W; i++) begin
                    if (asm_q.cnt == CNT_W'(i)) begin
                        asm_d.acc[WORD_W-1-i] = sbit;
                    end
                end
            end
        end

        if (fmt == FMT_RJ16) begin
            word = {asm_q.acc[SHORT_W-1:0], {PAD_W{1'b0}}};
        end else begin
            word = asm_q.acc;
        end

        if ((fmt == FMT_RJ24) || (fmt == FMT_LJ24)) begin
            word_ok = (asm_q.cnt >= NEED_FUL);
        end else begin
            word_ok = (asm_q.cnt >= NEED_SHT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_q <= '0;
        end else begin
            asm_q <= asm_d;
        end
    end

    // R3: the first slot of a left-aligned half lands in the MSB
    assert_msb_first_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (half_start && !lsb_mode) |=> (asm_q.acc[WORD_W-1] == $past(sbit)));

    // R5: in right-justified framings the newest bit is always the LSB
    assert_lsb_newest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lsb_mode |=> (asm_q.acc[0] == $past(sbit)));

    // R8: the slot count restarts at each half and never falls inside one
    assert_cnt_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        half_start |=> (asm_q.cnt == CNT_W'(1)));

    assert_cnt_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_start) |=> (asm_q.cnt >= $past(asm_q.cnt)));

endmodule

// File: rtl/pcm_rx_pair_out.sv
module pcm_rx_pair_out #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_close,
    input  logic              closed_left,
    input  logic [WORD_W-1:0] word,
    input  logic              word_ok,
    output logic [WORD_W-1:0] left_q,
    output logic [WORD_W-1:0] right_q,
    output logic              valid_q
);

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic              hold_ok;
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
        logic              valid;
    } pair_t;

    pair_t pair_d, pair_q;

    always_comb begin
        pair_d       = pair_q;
        pair_d.valid = 1'b0;
        if (half_close) begin
            if (closed_left) begin
                pair_d.hold    = word;
                pair_d.hold_ok = word_ok;
            end else begin
                if (pair_q.hold_ok && word_ok) begin
                    pair_d.left  = pair_q.hold;
                    pair_d.right = word;
                    pair_d.valid = 1'b1;
                end
                pair_d.hold_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= '0;
        end else begin
            pair_q <= pair_d;
        end
    end

    assign left_q  = pair_q.left;
    assign right_q = pair_q.right;
    assign valid_q = pair_q.valid;

    // R7: strobe lasts one cycle
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R7: outputs move only together with the strobe
    assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_q) |-> ($stable(left_q) && $stable(right_q)));

    // R7: a strobe always follows the close of a right half
    assert_valid_after_right_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(half_close && !closed_left));

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
    import pcm_rx_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 16,
    parameter int CNT_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lrclk,
    input  logic              sdata_pri,
    input  logic              sdata_sec,
    input  logic [1:0]        fmt,
    input  logic              ctl_3wire,
    input  logic              sec_sel,
    output logic [WORD_W-1:0] left_out,
    output logic [WORD_W-1:0] right_out,
    output logic              sample_valid
);

    fmt_e              fmt_sel;
    logic              ser_bit;
    logic              half_start;
    logic              half_close;
    logic              closed_left;
    logic [WORD_W-1:0] word;
    logic              word_ok;

    always_comb begin
        fmt_sel = fmt_e'(fmt);
        ser_bit = (ctl_3wire && sec_sel) ? sdata_sec : sdata_pri;
    end

    pcm_rx_frame_sync u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .lrclk       (lrclk),
        .fmt         (fmt_sel),
        .half_start  (half_start),
        .half_close  (half_close),
        .closed_left (closed_left)
    );

    pcm_rx_word_asm #(
        .WORD_W  (WORD_W),
        .SHORT_W (SHORT_W),
        .CNT_W   (CNT_W)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (fmt_sel),
        .sbit       (ser_bit),
        .half_start (half_start),
        .word       (word),
        .word_ok    (word_ok)
    );

    pcm_rx_pair_out #(
        .WORD_W (WORD_W)
    ) u_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .half_close  (half_close),
        .closed_left (closed_left),
        .word        (word),
        .word_ok     (word_ok),
        .left_q      (left_out),
        .right_q     (right_out),
        .valid_q     (sample_valid)
    );

endmodule

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lrclk = 1'b0;
    logic        sd_a = 1'b0;
    logic        sd_b = 1'b0;
    logic [1:0]  fmt = 2'b11;
    logic        ctl3 = 1'b0;
    logic        ssel = 1'b0;
    logic [23:0] left_out;
    logic [23:0] right_out;
    logic        valid;

    always #4 clk = ~clk;

    pcm_serial_rx u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .lrclk        (lrclk),
        .sdata_pri    (sd_a),
        .sdata_sec    (sd_b),
        .fmt          (fmt),
        .ctl_3wire    (ctl3),
        .sec_sel      (ssel),
        .left_out     (left_out),
        .right_out    (right_out),
        .sample_valid (valid)
    );

    int total = 0, bad = 0, mon_total = 0, mon_bad = 0, cycles = 0;
    bit done = 1'b0;
    logic [23:0] exp_l[$];
    logic [23:0] exp_r[$];
    string       exp_tag[$];
    logic        pend_a = 1'b0, pend_b = 1'b0;

    // Serial bit for effective slot j of a half of s slots.
    function automatic logic sbit_f(int f, int s, logic [23:0] w, int j);
        int b;
        b = s - 1 - j;
        case (f)
            0:       return (b <= 15) ? w[8+b] : logic'(j % 2);
            1:       return (b <= 23) ? w[b]   : logic'(j % 2);
            default: return (j < 24) ? w[23-j] : logic'(j % 2);
        endcase
    endfunction

    function automatic logic [23:0] exp_word(int f, int s, logic [23:0] w);
        logic [23:0] m;
        if (f == 0) return {w[23:8], 8'h00};
        if (f == 3 && s < 24) begin
            m = 24'hFFFFFF << (24 - s);
            return w & m;
        end
        return w;
    endfunction

    function automatic int need(int f);
        return (f == 1 || f == 2) ? 24 : 16;
    endfunction

    function automatic logic [23:0] pat(int n);
        case (n % 8)
            0: return 24'h7FFFFF;
            1: return 24'h800000;
            2: return 24'h000000;
            default: return 24'(n * 32'h009E3779 + 32'h002468AD);
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [23:0] act, logic [23:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic drive(logic lr, logic a, logic b);
        @(negedge clk);
        lrclk = lr;
        sd_a  = a;
        sd_b  = b;
    endtask

    task automatic send_half(int f, int s, logic lr, logic [23:0] wa, logic [23:0] wb);
        for (int k = 0; k < s; k++) begin
            if (f == 3) begin
                if (k == 0) drive(lr, pend_a, pend_b);
                else        drive(lr, sbit_f(f, s, wa, k-1), sbit_f(f, s, wb, k-1));
            end else begin
                drive(lr, sbit_f(f, s, wa, k), sbit_f(f, s, wb, k));
            end
        end
        if (f == 3) begin
            pend_a = sbit_f(f, s, wa, s-1);
            pend_b = sbit_f(f, s, wb, s-1);
        end
    endtask

    task automatic send_frame(int f, int s, logic [23:0] la, logic [23:0] ra,
                              logic [23:0] lb, logic [23:0] rb);
        logic left_lv;
        left_lv = (f == 3) ? 1'b0 : 1'b1;
        send_half(f, s, left_lv, la, lb);
        send_half(f, s, ~left_lv, ra, rb);
    endtask

    task automatic start_group(int f, bit tw, bit sb, logic idle_lr);
        @(negedge clk);
        rst_n = 1'b0;
        fmt   = 2'(f);
        ctl3  = tw;
        ssel  = sb;
        lrclk = idle_lr;
        sd_a  = 1'b0;
        sd_b  = 1'b0;
        pend_a = 1'b0;
        pend_b = 1'b0;
        exp_l.delete();
        exp_r.delete();
        exp_tag.delete();
        repeat (3) @(negedge clk);
        chk(valid == 1'b0, "R1 valid in reset", 24'(valid), 24'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: cleared outputs after reset
        chk(valid == 1'b0, "R1 valid after reset", 24'(valid), 24'h0);
        chk(left_out == 24'h0, "R1 left after reset", left_out, 24'h0);
        chk(right_out == 24'h0, "R1 right after reset", right_out, 24'h0);
    endtask

    task automatic end_group(int f);
        logic idle_lr;
        idle_lr = (f == 3) ? 1'b1 : 1'b0;
        send_frame(f, 32, 24'h0, 24'h0, 24'h0, 24'h0);
        repeat (6) drive(idle_lr, 1'b0, 1'b0);
        // R8/R10: every expected pair arrived, no pulse was missing
        chk(exp_l.size() == 0, "R8/R10 missing pulses", 24'(exp_l.size()), 24'h0);
    endtask

    // Output monitor: pairs in order, one-cycle strobe, hold between strobes.
    logic        prev_v = 1'b0;
    logic [23:0] pl = '0, pr = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_v = 1'b0;
            pl = '0;
            pr = '0;
        end else begin
            mon_total++;
            if (valid) begin
                if (prev_v) begin
                    mon_bad++;
                    $display("FAIL R7 strobe longer than one cycle actual=1 expected=0");
                end
                if (exp_l.size() == 0) begin
                    mon_bad++;
                    $display("FAIL R8/R10 unexpected pulse actual=%h/%h expected=none",
                             left_out, right_out);
                end else begin
                    logic [23:0] el, er;
                    string t;
                    el = exp_l.pop_front();
                    er = exp_r.pop_front();
                    t  = exp_tag.pop_front();
                    mon_total += 2;
                    if (left_out != el) begin
                        mon_bad++;
                        $display("FAIL %s left actual=%h expected=%h", t, left_out, el);
                    end
                    if (right_out != er) begin
                        mon_bad++;
                        $display("FAIL %s right actual=%h expected=%h", t, right_out, er);
                    end
                end
            end else if (left_out != pl || right_out != pr) begin
                mon_bad++;
                $display("FAIL R7 outputs moved without strobe actual=%h/%h expected=%h/%h",
                         left_out, right_out, pl, pr);
            end
            prev_v = valid;
            pl = left_out;
            pr = right_out;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000 && !done) begin
            done = 1'b1;
            $display("FAIL R7 watchdog expired actual=%0d expected=finished", cycles);
            $display("  test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
            $finish;
        end
    end

    initial begin
        int sizes[9] = '{12, 16, 20, 23, 24, 25, 32, 48, 64};
        int n = 0;

        // Format sweep: R3 (fmt 10), R4 (fmt 11), R5 (fmt 01), R6 (fmt 00);
        // short halves below the minimum cover R8; full-scale words cover R2.
        for (int f = 0; f < 4; f++) begin
            start_group(f, 1'b1, 1'b0, (f == 3) ? 1'b1 : 1'b0);
            foreach (sizes[i]) begin
                for (int rep = 0; rep < 2; rep++) begin
                    logic [23:0] la, ra;
                    la = pat(n);
                    ra = pat(n + 1);
                    n += 2;
                    send_frame(f, sizes[i], la, ra, ~la, ~ra);
                    if (sizes[i] >= need(f)) begin
                        exp_l.push_back(exp_word(f, sizes[i], la));
                        exp_r.push_back(exp_word(f, sizes[i], ra));
                        case (f)
                            0: exp_tag.push_back("R6");
                            1: exp_tag.push_back("R5");
                            2: exp_tag.push_back("R2/R3");
                            default: exp_tag.push_back("R4");
                        endcase
                    end
                end
            end
            end_group(f);
        end

        // R9: source selection over all control combinations
        for (int c = 0; c < 4; c++) begin
            start_group(2, c[1], c[0], 1'b0);
            for (int rep = 0; rep < 2; rep++) begin
                logic [23:0] la, ra, lb, rb;
                la = pat(n + 3);
                ra = pat(n + 4);
                lb = ~pat(n + 5);
                rb = pat(n + 6) ^ 24'h5A5A5A;
                n += 4;
                send_frame(2, 32, la, ra, lb, rb);
                exp_l.push_back((c == 3) ? lb : la);
                exp_r.push_back((c == 3) ? rb : ra);
                exp_tag.push_back("R9");
            end
            end_group(2);
        end

        // R10: reset released in the middle of a left half
        start_group(1, 1'b1, 1'b0, 1'b1);
        repeat (10) drive(1'b1, 1'b1, 1'b0);
        send_frame(1, 32, 24'h123456, 24'h654321, 24'h0, 24'h0);
        send_frame(1, 32, 24'hABCDEF, 24'h13579B, 24'h0, 24'h0);
        exp_l.push_back(24'hABCDEF);
        exp_r.push_back(24'h13579B);
        exp_tag.push_back("R10");
        end_group(1);

        done = 1'b1;
        total += mon_total;
        bad   += mon_bad;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule